// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block takes one asynchronous non-maskable interrupt pin and turns it into a maskable, registered interrupt request for a processor. The pin is first passed through a two-flop synchronizer. A detector then produces a one-cycle event according to a programmable trigger type: active-low level, active-high level, falling edge or rising edge. Each event sets a sticky pending flag. Software acknowledges the flag by writing one to it. A separate enable bit gates the flag onto the request output.

Software reaches three 32-bit registers through a simple register port. Writes take effect on the clock edge and reads are combinational from the address. The control register always sits at byte offset 0x00. A build-time parameter chooses where the pending and enable registers sit, from three fixed layouts. This lets one RTL body serve several address maps.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset, control reads 0 (active-low level), pending reads 0, enable reads 0, and irq_out is 0.
- R2: Control bits [1:0] select the trigger type: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge.
- R3: The pin is synchronized through two flops, and an edge is found by comparing the synchronized value with its value one cycle earlier. A pin change set up before clock edge k shows as pending after edge k+2.
- R4: In the edge modes, an event sets pending and pending holds until bit 0 of the pending register is written with 1. A write with bit 0 = 0 leaves pending unchanged.
- R5: In the level modes, pending is set on every cycle the synchronized pin is at its active level, so a clear while the level persists is overridden on the next edge.
- R6: irq_out is registered and equals (pending AND enable) from the previous cycle. Clearing enable bit 0 masks the request without discarding pending.
- R7: When a pending clear and a new event meet in the same cycle, pending stays set.
- R8: LAYOUT 0 puts pending at 0x04 and enable at 0x08. LAYOUT 1 puts pending at 0x04 and enable at 0x34. LAYOUT 2 puts pending at 0x08 and enable at 0x04. Pending and enable read back in bit 0, with zeros above.
- R9: Reads of any other offset return zero. Writes to any other offset change no register.
- R10: Control bits [31:2] are plain read/write storage and read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The pin is driven in four kinds of pattern. Single clean transitions separate the two edge types from each other and from the levels. A long held active level shows whether a clear is overridden in level modes and held in edge modes. A pulse whose event meets a clear in the same cycle checks that the event wins. Random toggling with random register writes, including writes to unmapped and masked offsets, is compared every cycle against a cycle-accurate model held in the bench. Two extra instances built with the other layouts check that the address decode moves with the parameter.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  localparam logic [7:0] CTRL_OFFSET = 8'h00;

  // byte offset of the pending register for a given layout
  function automatic logic [7:0] pend_offset(input int unsigned layout);
    case (layout)
      2:       return 8'h08;
      default: return 8'h04;
    endcase
  endfunction

  // byte offset of the enable register for a given layout
  function automatic logic [7:0] en_offset(input int unsigned layout);
    case (layout)
      1:       return 8'h34;
      2:       return 8'h04;
      default: return 8'h08;
    endcase
  endfunction

  // one-cycle trigger event from the current and previous synchronized pin
  function automatic logic trig_event(input trig_e mode, input logic cur, input logic prev);
    case (mode)
      TRIG_LVL_LO: return ~cur;
      TRIG_FALL:   return prev & ~cur;
      TRIG_LVL_HI: return cur;
      default:     return cur & ~prev;
    endcase
  endfunction

endpackage

// File: rtl/nmi_line_sync.sv
module nmi_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_line_detect.sv
module nmi_line_detect
  import nmi_line_pkg::*;
#(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_sync,
  input  trig_e mode,
  output logic  evt
);
  logic pin_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= RESET_VAL;
    else        pin_prev_q <= pin_sync;
  end

  assign evt = trig_event(mode, pin_sync, pin_prev_q);

  // R3: a rising-mode event requires a low sample one cycle earlier
  a_r3_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_RISE && evt) |-> (pin_sync && !$past(pin_sync)));
  // R3: a falling-mode event requires a high sample one cycle earlier
  a_r3_fall_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_FALL && evt) |-> (!pin_sync && $past(pin_sync)));
endmodule

// File: rtl/nmi_line_regs.sv
module nmi_line_regs
  import nmi_line_pkg::*;
#(
  parameter int unsigned LAYOUT = 0,
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  output logic [DATA_W-1:0] rdata,
  output trig_e             mode,
  output logic              pend,
  output logic              en
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(pend_offset(LAYOUT));
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(en_offset(LAYOUT));

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic              en_q;
  logic              hit_ctrl, hit_pend, hit_en, hit_any;
  logic              clr_hit;

  assign hit_ctrl = (addr == A_CTRL);
  assign hit_pend = (addr == A_PEND);
  assign hit_en   = (addr == A_EN);
  assign hit_any  = hit_ctrl | hit_pend | hit_en;
  assign clr_hit  = we & hit_pend & wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (we && hit_ctrl) ctrl_q <= wdata;
      if (we && hit_en)   en_q   <= wdata[0];
      pend_q <= evt | (pend_q & ~clr_hit);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)      rdata = ctrl_q;
    else if (hit_pend) rdata[0] = pend_q;
    else if (hit_en)   rdata[0] = en_q;
  end

  assign mode = trig_e'(ctrl_q[1:0]);
  assign pend = pend_q;
  assign en   = en_q;

  // R7: an event always leaves pending set, even against a clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);
  // R4: a clear with no new event drops pending
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && clr_hit && !evt) |=> !pend);
  // R4: without a clear, pending holds
  a_r4_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_hit) |=> pend);
  // R9: unmapped writes change no register
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit_any) |=> ($stable(ctrl_q) && $stable(en_q)));
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int unsigned LAYOUT      = 0,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  // the pin idles high so that the reset trigger (active-low level) stays quiet
  localparam logic PIN_IDLE = 1'b1;

  logic  pin_sync;
  logic  evt;
  trig_e mode;
  logic  pend, en;
  logic  irq_q;

  nmi_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(nmi_pin), .d_sync(pin_sync)
  );

  nmi_line_detect #(.RESET_VAL(PIN_IDLE)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .mode(mode), .evt(evt)
  );

  nmi_line_regs #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .evt(evt), .rdata(bus_rdata), .mode(mode), .pend(pend), .en(en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend & en;
  end

  assign irq_out = irq_q;

  // R6: the request follows gated pending by one cycle
  a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(pend && en));
  // R6: a masked line never raises the request
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !irq_out);
endmodule

// File: tb/nmi_line_ctrl_test.sv
module nmi_line_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  logic b_we = 1'b0, c_we = 1'b0;
  logic [AW-1:0] b_addr = '0, c_addr = '0;
  logic [DW-1:0] b_wdata = '0, c_wdata = '0;
  logic [DW-1:0] b_rdata, c_rdata;
  logic b_irq, c_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nmi_line_ctrl #(.LAYOUT(0)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(pin), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));
  nmi_line_ctrl #(.LAYOUT(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .nmi_pin(1'b1), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq_out(b_irq));
  nmi_line_ctrl #(.LAYOUT(2)) uut_c (
    .clk(clk), .rst_n(rst_n), .nmi_pin(1'b1), .bus_we(c_we), .bus_addr(c_addr),
    .bus_wdata(c_wdata), .bus_rdata(c_rdata), .irq_out(c_irq));

  // reference model for layout A, written from the requirements
  logic [DW-1:0] m_ctrl;
  logic m_pend, m_en, m_irq, m_s1, m_s2, m_prev;

  function automatic logic m_event(input logic [1:0] mode, input logic cur, input logic prev);
    if (mode == 2'd0) return !cur;          // R2 active-low level
    if (mode == 2'd2) return cur;           // R2 active-high level
    if (mode == 2'd1) return prev && !cur;  // R2 falling edge
    return cur && !prev;                    // R2 rising edge
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h04) return {31'd0, m_pend};
    if (a == 8'h08) return {31'd0, m_en};
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_pend <= 1'b0; m_en <= 1'b0; m_irq <= 1'b0;
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
    end else begin
      m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
      m_irq <= m_pend && m_en;
      m_pend <= m_event(m_ctrl[1:0], m_s2, m_prev) ||
                (m_pend && !(we && addr == 8'h04 && wdata[0]));
      if (we && addr == 8'h00) m_ctrl <= wdata;
      if (we && addr == 8'h08) m_en <= wdata[0];
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at a falling edge, let one rising edge pass, compare with the model
  task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic p);
    we = w; addr = a; wdata = d; pin = p;
    @(posedge clk);
    @(negedge clk);
    chk("R6 irq_out vs model", {31'd0, irq}, {31'd0, m_irq});
    chk("R8 read vs model", rdata, m_read(a));
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    addr = a; we = 1'b0;
    #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic bc_cyc(input bit is_c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (is_c) begin c_we = w; c_addr = a; c_wdata = d; end
    else      begin b_we = w; b_addr = a; b_wdata = d; end
    @(posedge clk);
    @(negedge clk);
    c_we = 1'b0; b_we = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, 32'd0, "R1 ctrl reset");
    rd(8'h04, 32'd0, "R1 pend reset");
    rd(8'h08, 32'd0, "R1 en reset");
    chk("R1 irq reset", {31'd0, irq}, 32'd0);

    // R2/R3 rising edge latency
    cyc(1, 8'h00, 32'd3, 1'b0);
    cyc(1, 8'h08, 32'd1, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(0, 8'h04, 0, 1'b1);           // edge k
    chk("R3 not yet at k", rdata, 32'd0);
    cyc(0, 8'h04, 0, 1'b1);           // edge k+1
    chk("R3 not yet at k+1", rdata, 32'd0);
    cyc(0, 8'h04, 0, 1'b1);           // edge k+2
    chk("R3 pending at k+2", rdata, 32'd1);
    cyc(0, 8'h04, 0, 1'b1);
    chk("R6 irq one cycle after", {31'd0, irq}, 32'd1);

    // R4 hold, write-zero no effect, write-one clear
    cyc(1, 8'h04, 32'hFFFF_FFFE, 1'b1);
    chk("R4 write zero keeps pending", rdata, 32'd1);
    cyc(1, 8'h04, 32'd1, 1'b1);
    chk("R4 write one clears", rdata, 32'd0);

    // R6 masking keeps pending
    cyc(0, 8'h04, 0, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(1, 8'h00, 32'd1, 1'b0);       // falling mode, pin already low
    cyc(0, 8'h04, 0, 1'b1);
    cyc(0, 8'h04, 0, 1'b1);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(1, 8'h08, 32'd0, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    chk("R6 masked keeps pending", rdata, 32'd1);
    chk("R6 masked irq low", {31'd0, irq}, 32'd0);
    cyc(1, 8'h08, 32'd1, 1'b0);
    cyc(1, 8'h04, 32'd1, 1'b0);

    // R5 level-high re-asserts after clear
    cyc(1, 8'h00, 32'd2, 1'b1);
    cyc(0, 8'h04, 0, 1'b1);
    cyc(0, 8'h04, 0, 1'b1);
    cyc(1, 8'h04, 32'd1, 1'b1);
    chk("R5 level re-sets after clear", rdata, 32'd1);

    // R7 clear meets new event
    cyc(1, 8'h00, 32'd3, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(0, 8'h04, 0, 1'b0);
    cyc(0, 8'h04, 0, 1'b1);           // edge k
    cyc(0, 8'h04, 0, 1'b1);           // edge k+1, event now active
    cyc(1, 8'h04, 32'd1, 1'b1);       // clear sampled with event at k+2
    chk("R7 event wins over clear", rdata, 32'd1);

    // R10 upper control bits and R9 unmapped offsets
    cyc(1, 8'h00, 32'hABCD_1233, 1'b1);
    chk("R10 ctrl upper bits", rdata, 32'hABCD_1233);
    cyc(1, 8'h10, 32'hFFFF_FFFF, 1'b1);
    chk("R9 unmapped reads zero", rdata, 32'd0);
    rd(8'h00, 32'hABCD_1233, "R9 unmapped write ignored");
    cyc(1, 8'h34, 32'd0, 1'b1);
    rd(8'h08, 32'd1, "R9 layout B offset ignored in A");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic p;
      int sel;
      sel = int'($urandom_range(0, 4));
      case (sel)
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h34;
        default: a = 8'($urandom);
      endcase
      w = ($urandom_range(0, 3) == 0);
      d = $urandom;
      if (a == 8'h00 && $urandom_range(0, 1) == 1) d[31:2] = '0;
      p = ($urandom_range(0, 5) == 0) ? !pin : pin;
      cyc(w, a, d, p);
    end

    // R8 layout B: pending 0x04, enable 0x34
    bc_cyc(0, 1, 8'h34, 32'd1);
    b_addr = 8'h34; #0.5; chk("R8 layout B enable", b_rdata, 32'd1);
    b_addr = 8'h08; #0.5; chk("R8 layout B 0x08 unmapped", b_rdata, 32'd0);
    b_addr = 8'h04; #0.5; chk("R8 layout B pending", b_rdata, 32'd0);
    bc_cyc(0, 1, 8'h00, 32'd7);
    b_addr = 8'h00; #0.5; chk("R8 layout B ctrl", b_rdata, 32'd7);

    // R8 layout C: pending 0x08, enable 0x04
    bc_cyc(1, 1, 8'h04, 32'd1);
    c_addr = 8'h04; #0.5; chk("R8 layout C enable", c_rdata, 32'd1);
    c_addr = 8'h08; #0.5; chk("R8 layout C pending", c_rdata, 32'd0);
    c_addr = 8'h34; #0.5; chk("R8 layout C 0x34 unmapped", c_rdata, 32'd0);
    chk("R6 layout C irq idle", {31'd0, c_irq}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule